// File: doc/BRIEF.md
# Time-Division Stereo Sound Multiplexer

This block interleaves up to eight sound channels into a pair of output streams, one for the left side and one for the right. Each channel holds one 8-bit log-coded sample byte. A fetch engine outside the block supplies these bytes when the block asks for them. A frame always has eight slots, and each slot carries one channel. The number of active channels can be 1, 2, 4 or 8. When fewer than eight are active, the channel index wraps around, so the unused slot positions repeat the active channels.

Each slot lasts a number of sound-clock ticks set by a frequency register. The sound clock reaches the block as a one-cycle enable. Every channel has a 3-bit pan code that sets what share of frames sends that channel to the left output and what share sends it to the right. In each slot, the side that does not receive the sample carries the silent code 8'h00.

A small write port holds the pan codes, the frequency value and the channel-count code. None of them acts at once: each is copied into the live settings at the next frame boundary. The sequencer is a four-state machine:
- SEQ_IDLE waits for the first sound tick after reset, then goes to SEQ_LOAD.
- SEQ_LOAD copies the pending settings into the live settings and returns to slot 0, then goes to SEQ_EMIT.
- SEQ_EMIT publishes one slot on the outputs, then goes to SEQ_HOLD.
- SEQ_HOLD counts ticks. After the last tick it goes to SEQ_EMIT for the next slot, or to SEQ_LOAD after slot 7.

Top module: `snd_tdm_mux`

## Requirements
- R1: Reset state. While reset is held and after it is released, `slot_stb`, `smp_req`, `left_out`, `right_out` and `slot_ch` are all zero. The default settings are eight channels (mode code 3), frequency 0 and pan code 4 on every channel.
- R2: A frame has eight slots. When the sound tick arrives every 4 clocks, the strobes of slots 2 to 7 each come 4·(F+2) clocks after the strobe before them, where F is the live frequency value.
- R3: Slot s carries channel s mod N, reported on `slot_ch`. N is set by the mode code: 0 gives 1 channel, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: The pan code sets a left share L: code 0→4, 1→8, 2→7, 3→6, 4→4, 5→2, 6→1, 7→0. Frame phase k is the number of frames since reset, mod 8. When k < L the sample goes to `left_out` and `right_out` is 8'h00; otherwise the sample goes to `right_out` and `left_out` is 8'h00.
- R5: In slot s with s < N, `smp_req` pulses in the strobe cycle with `smp_req_ch` = s. In every other slot it stays low.
- R6: A byte written through `smp_vld`/`smp_ch`/`smp_byte` appears in the next slot of that channel. The channel keeps that byte until another byte is written to it.
- R7: Writes to the frequency, mode or pan registers take effect at the start of the next frame. The slots still to come in the current frame keep the old settings.
- R8: Register map, with `cfg_addr` 4 bits:
  - addresses 0 to 7 hold the pan code of that channel in `cfg_wdata[2:0]`;
  - address 8 holds the frequency in `cfg_wdata[7:0]`;
  - address 9 holds the mode code in `cfg_wdata[1:0]`;
  - writes to addresses 10 to 15 change nothing.
- R9: `slot_stb` lasts one cycle. `left_out` and `right_out` change only together with a strobe.
- R10: While `snd_ce` stays low, no slot advances and no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| snd_ce | input | 1 | One-cycle sound-clock tick |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| smp_vld | input | 1 | Sample byte delivery |
| smp_ch | input | 3 | Channel of delivered byte |
| smp_byte | input | 8 | Log-coded sample byte |
| smp_req | output | 1 | Sample request pulse |
| smp_req_ch | output | 3 | Channel being requested |
| slot_stb | output | 1 | New slot published |
| slot_ch | output | 3 | Channel in current slot |
| left_out | output | 8 | Left stream word |
| right_out | output | 8 | Right stream word |

## Verification
A slot or frame-phase counter that has drifted shows up on the next strobe. The channel number goes out of the wrap order, or a sample moves to the wrong side once the frame phase passes a channel's left share, so one frame is enough to expose it. A tick counter that is wrong shows up as a strobe spacing other than 4·(F+2) clocks between the strobes of slots 2 to 7. Settings that are picked up too early show up in the slots that follow a write made in the middle of a frame, because the spacing or the routing changes within that same frame.

// File: rtl/snd_pkg.sv
package snd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_EMIT,
        SEQ_HOLD
    } seq_state_e;

    // Share of frames (out of eight) that steer a channel to the left side.
    function automatic logic [3:0] left_share(input logic [2:0] pos);
        logic [3:0] s;
        unique case (pos)
            3'd1:    s = 4'd8;
            3'd2:    s = 4'd7;
            3'd3:    s = 4'd6;
            3'd5:    s = 4'd2;
            3'd6:    s = 4'd1;
            3'd7:    s = 4'd0;
            default: s = 4'd4;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/snd_cfg_regs.sv
module snd_cfg_regs #(
    parameter int CH     = 8,
    parameter int POS_W  = 3,
    parameter int FREQ_W = 8,
    parameter int ADDR_W = 4,
    parameter int MODE_W = 2,
    parameter logic [POS_W-1:0] PAN_RST = 3'd4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [FREQ_W-1:0]           cfg_wdata,
    input  logic                        load,
    output logic [FREQ_W-1:0]           act_freq,
    output logic [MODE_W-1:0]           act_mode,
    output logic [CH-1:0][POS_W-1:0]    act_pan
);
    localparam int ADDR_FREQ = CH;
    localparam int ADDR_MODE = CH + 1;
    localparam logic [MODE_W-1:0] MODE_RST = MODE_W'($clog2(CH));

    logic [FREQ_W-1:0]        pend_freq;
    logic [MODE_W-1:0]        pend_mode;
    logic [CH-1:0][POS_W-1:0] pend_pan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_freq <= '0;
            pend_mode <= MODE_RST;
        end else if (cfg_we) begin
            if (int'(cfg_addr) == ADDR_FREQ) pend_freq <= cfg_wdata;
            if (int'(cfg_addr) == ADDR_MODE) pend_mode <= cfg_wdata[MODE_W-1:0];
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_pan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_pan[c] <= PAN_RST;
            else if (cfg_we && int'(cfg_addr) == c)
                pend_pan[c] <= cfg_wdata[POS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_freq <= '0;
            act_mode <= MODE_RST;
            act_pan  <= {CH{PAN_RST}};
        end else if (load) begin
            act_freq <= pend_freq;
            act_mode <= pend_mode;
            act_pan  <= pend_pan;
        end
    end

    // R7
    live_freq_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_freq));
    // R7
    live_mode_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_mode));

endmodule

// File: rtl/snd_sample_store.sv
module snd_sample_store #(
    parameter int CH    = 8,
    parameter int SMP_W = 8,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [SMP_W-1:0] wr_byte,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [SMP_W-1:0] rd_byte
);
    logic [SMP_W-1:0] held [CH];

    for (genvar c = 0; c < CH; c++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                held[c] <= '0;
            else if (wr_vld && int'(wr_ch) == c)
                held[c] <= wr_byte;
        end
    end

    assign rd_byte = held[rd_ch];

    // R6
    sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> (held[$past(wr_ch)] == $past(wr_byte)));

endmodule

// File: rtl/snd_slot_seq.sv
module snd_slot_seq
    import snd_pkg::*;
#(
    parameter int CH     = 8,
    parameter int FREQ_W = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_ce,
    input  logic [FREQ_W-1:0] act_freq,
    output logic              load,
    output logic              emit,
    output logic [CH_W-1:0]   slot_idx,
    output logic [2:0]        phase
);
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(CH - 1);

    seq_state_e        state_q, state_d;
    logic [FREQ_W:0]   tick_cnt;
    logic              last_tick;

    assign last_tick = snd_ce && (tick_cnt == ({1'b0, act_freq} + 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (snd_ce) state_d = SEQ_LOAD;
            SEQ_LOAD: state_d = SEQ_EMIT;
            SEQ_EMIT: state_d = SEQ_HOLD;
            SEQ_HOLD: if (last_tick)
                          state_d = (slot_idx == LAST_SLOT) ? SEQ_LOAD : SEQ_EMIT;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            slot_idx <= '0;
            phase    <= '0;
        end else begin
            unique case (state_q)
                SEQ_EMIT: tick_cnt <= '0;
                SEQ_HOLD: begin
                    if (last_tick) begin
                        tick_cnt <= '0;
                        if (slot_idx == LAST_SLOT) begin
                            slot_idx <= '0;
                            phase    <= phase + 3'd1;
                        end else begin
                            slot_idx <= slot_idx + 1'b1;
                        end
                    end else if (snd_ce) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                default: tick_cnt <= '0;
            endcase
        end
    end

    assign load = (state_q == SEQ_LOAD);
    assign emit = (state_q == SEQ_EMIT);

    // R2
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD) |-> (tick_cnt <= ({1'b0, act_freq} + 1'b1)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD && !snd_ce) |=> (state_q == SEQ_HOLD && $stable(slot_idx)));
    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (slot_idx == '0));

endmodule

// File: rtl/snd_pan_route.sv
module snd_pan_route
    import snd_pkg::*;
#(
    parameter int CH     = 8,
    parameter int SMP_W  = 8,
    parameter int POS_W  = 3,
    parameter int CH_W   = 3,
    parameter int MODE_W = 2
) (
    input  logic [CH_W-1:0]           slot_idx,
    input  logic [MODE_W-1:0]         act_mode,
    input  logic [CH-1:0][POS_W-1:0]  act_pan,
    input  logic [2:0]                phase,
    input  logic [SMP_W-1:0]          sample,
    output logic [CH_W-1:0]           chan,
    output logic                      first_use,
    output logic [SMP_W-1:0]          left_w,
    output logic [SMP_W-1:0]          right_w
);
    logic [CH_W-1:0] mask;
    logic [3:0]      share;
    logic            go_left;

    always_comb begin
        for (int i = 0; i < CH_W; i++) mask[i] = (i < int'(act_mode));
        chan      = slot_idx & mask;
        first_use = ((slot_idx & ~mask) == '0);
        share     = left_share(act_pan[chan]);
        go_left   = ({1'b0, phase} < share);
        left_w    = go_left ? sample : '0;
        right_w   = go_left ? '0 : sample;
    end

endmodule

// File: rtl/snd_tdm_mux.sv
module snd_tdm_mux
    import snd_pkg::*;
#(
    parameter int CH     = 8,
    parameter int SMP_W  = 8,
    parameter int FREQ_W = 8,
    parameter int POS_W  = 3,
    parameter int ADDR_W = 4,
    localparam int CH_W   = $clog2(CH),
    localparam int MODE_W = $clog2($clog2(CH) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_ce,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FREQ_W-1:0] cfg_wdata,
    input  logic              smp_vld,
    input  logic [CH_W-1:0]   smp_ch,
    input  logic [SMP_W-1:0]  smp_byte,
    output logic              smp_req,
    output logic [CH_W-1:0]   smp_req_ch,
    output logic              slot_stb,
    output logic [CH_W-1:0]   slot_ch,
    output logic [SMP_W-1:0]  left_out,
    output logic [SMP_W-1:0]  right_out
);
    logic [FREQ_W-1:0]        act_freq;
    logic [MODE_W-1:0]        act_mode;
    logic [CH-1:0][POS_W-1:0] act_pan;
    logic                     load, emit, first_use;
    logic [CH_W-1:0]          slot_idx, chan;
    logic [2:0]               phase;
    logic [SMP_W-1:0]         sample, left_w, right_w;

    snd_cfg_regs #(
        .CH(CH), .POS_W(POS_W), .FREQ_W(FREQ_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .load(load), .act_freq(act_freq),
        .act_mode(act_mode), .act_pan(act_pan)
    );

    snd_slot_seq #(
        .CH(CH), .FREQ_W(FREQ_W), .CH_W(CH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .snd_ce(snd_ce), .act_freq(act_freq),
        .load(load), .emit(emit), .slot_idx(slot_idx), .phase(phase)
    );

    snd_sample_store #(
        .CH(CH), .SMP_W(SMP_W), .CH_W(CH_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_vld(smp_vld), .wr_ch(smp_ch),
        .wr_byte(smp_byte), .rd_ch(chan), .rd_byte(sample)
    );

    snd_pan_route #(
        .CH(CH), .SMP_W(SMP_W), .POS_W(POS_W), .CH_W(CH_W), .MODE_W(MODE_W)
    ) u_route (
        .slot_idx(slot_idx), .act_mode(act_mode), .act_pan(act_pan),
        .phase(phase), .sample(sample), .chan(chan), .first_use(first_use),
        .left_w(left_w), .right_w(right_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_stb   <= 1'b0;
            smp_req    <= 1'b0;
            smp_req_ch <= '0;
            slot_ch    <= '0;
            left_out   <= '0;
            right_out  <= '0;
        end else if (emit) begin
            slot_stb   <= 1'b1;
            smp_req    <= first_use;
            smp_req_ch <= chan;
            slot_ch    <= chan;
            left_out   <= left_w;
            right_out  <= right_w;
        end else begin
            slot_stb   <= 1'b0;
            smp_req    <= 1'b0;
        end
    end

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |=> !slot_stb);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |-> ($stable(left_out) && $stable(right_out)));
    // R5
    req_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |-> slot_stb);
    // R4
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |-> (left_out == '0 || right_out == '0));
    // R3
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |-> ((32'(slot_ch) >> act_mode) == 0));

endmodule

// File: tb/snd_tdm_mux_bench.sv
module snd_tdm_mux_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snd_ce = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       smp_vld = 1'b0;
    logic [2:0] smp_ch = '0;
    logic [7:0] smp_byte = '0;
    logic       smp_req, slot_stb;
    logic [2:0] smp_req_ch, slot_ch;
    logic [7:0] left_out, right_out;

    always #5 clk = ~clk;

    snd_tdm_mux u_snd_tdm_mux (
        .clk(clk), .rst_n(rst_n), .snd_ce(snd_ce), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .smp_vld(smp_vld),
        .smp_ch(smp_ch), .smp_byte(smp_byte), .smp_req(smp_req),
        .smp_req_ch(smp_req_ch), .slot_stb(slot_stb), .slot_ch(slot_ch),
        .left_out(left_out), .right_out(right_out)
    );

    // Sound tick every 4 clocks
    logic       ce_en = 1'b1;
    int         div = 0;
    always @(negedge clk) begin
        div    <= (div + 1) % 4;
        snd_ce <= ce_en && (div == 3);
    end

    int unsigned cyc = 0;
    int unsigned frames_seen = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && slot_stb && smp_req && smp_req_ch == 3'd0)
            frames_seen <= frames_seen + 1;
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int         e_mode, e_freq;
    logic [2:0] e_pan [8];
    logic [7:0] e_smp [8];

    // {mode, freq, pan, seed}
    localparam logic [20:0] VEC [6] = '{
        {2'd3, 8'd0, 3'd4, 8'h11},
        {2'd0, 8'd3, 3'd1, 8'h21},
        {2'd1, 8'd1, 3'd7, 8'h35},
        {2'd2, 8'd5, 3'd2, 8'h47},
        {2'd3, 8'd2, 3'd6, 8'h59},
        {2'd2, 8'd0, 3'd0, 8'h63}
    };

    function automatic int share_of(input logic [2:0] p);
        case (p)
            3'd1: return 8;
            3'd2: return 7;
            3'd3: return 6;
            3'd5: return 2;
            3'd6: return 1;
            3'd7: return 0;
            default: return 4;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_smp(input int c, input logic [7:0] b);
        @(negedge clk);
        smp_vld = 1'b1; smp_ch = 3'(c); smp_byte = b;
        @(negedge clk);
        smp_vld = 1'b0;
        e_smp[c] = b;
    endtask

    task automatic wait_stb(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!slot_stb && n < 20000);
        if (!slot_stb) chk({tag, " strobe timeout"}, 0, 1);
    endtask

    // action 1: new sample on ch0 after slot 3; action 2: new freq after slot 3
    task automatic run_frame(input bit do_chk, input int action, input logic [7:0] aval);
        int n = 0;
        int ph, prev, nch, ch, sh, pend_freq;
        pend_freq = -1;
        do begin
            @(negedge clk);
            n++;
        end while (!(slot_stb && smp_req && smp_req_ch == 3'd0) && n < 20000);
        if (n >= 20000) chk("R2 frame timeout", 0, 1);
        ph   = int'(frames_seen % 8);
        prev = int'(cyc);
        nch  = 1 << e_mode;
        for (int s = 0; s < 8; s++) begin
            if (s > 0) wait_stb("R2");
            if (do_chk) begin
                ch = s % nch;
                sh = share_of(e_pan[ch]);
                chk("R3 slot_ch", int'(slot_ch), ch);
                chk("R4 left_out", int'(left_out), (ph < sh) ? int'(e_smp[ch]) : 0);
                chk("R4 right_out", int'(right_out), (ph < sh) ? 0 : int'(e_smp[ch]));
                chk("R5 smp_req", int'(smp_req), (s < nch) ? 1 : 0);
                if (s < nch) chk("R5 smp_req_ch", int'(smp_req_ch), s);
                if (s >= 2) chk("R2 slot spacing", int'(cyc) - prev, 4 * (e_freq + 2));
            end
            prev = int'(cyc);
            if (s == 3 && action == 1) wr_smp(0, aval);
            if (s == 3 && action == 2) begin
                wr_cfg(8, int'(aval));
                pend_freq = int'(aval);
            end
        end
        if (pend_freq >= 0) e_freq = pend_freq;
    endtask

    initial begin
        e_mode = 3;
        e_freq = 0;
        for (int c = 0; c < 8; c++) begin
            e_pan[c] = 3'd4;
            e_smp[c] = 8'h00;
        end
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk("R1 stb in reset", int'(slot_stb), 0);
        chk("R1 left in reset", int'(left_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stb after reset", int'(slot_stb), 0);
        chk("R1 req after reset", int'(smp_req), 0);
        chk("R1 right after reset", int'(right_out), 0);
        chk("R1 slot_ch after reset", int'(slot_ch), 0);

        // R1: default settings, R6: samples written then held
        for (int c = 0; c < 8; c++) wr_smp(c, 8'(8'h80 + c));
        run_frame(1, 0, 8'h00);
        run_frame(1, 0, 8'h00);

        // Vector table, R8 addresses 0..9
        for (int v = 0; v < 6; v++) begin
            for (int c = 0; c < 8; c++) begin
                wr_cfg(c, int'(VEC[v][10:8]));
                e_pan[c] = VEC[v][10:8];
            end
            wr_cfg(8, int'(VEC[v][18:11]));
            wr_cfg(9, int'(VEC[v][20:19]));
            e_freq = int'(VEC[v][18:11]);
            e_mode = int'(VEC[v][20:19]);
            for (int c = 0; c < 8; c++) wr_smp(c, 8'(int'(VEC[v][7:0]) + 17 * c));
            run_frame(0, 0, 8'h00);
            run_frame(1, 0, 8'h00);
            run_frame(1, 0, 8'h00);
        end

        // R4 / R8: distinct pan code per channel, eight channels
        for (int c = 0; c < 8; c++) begin
            wr_cfg(c, c);
            e_pan[c] = 3'(c);
        end
        wr_cfg(8, 1);
        wr_cfg(9, 3);
        e_freq = 1;
        e_mode = 3;
        run_frame(0, 0, 8'h00);
        for (int f = 0; f < 8; f++) run_frame(1, 0, 8'h00);

        // R6: mid-frame sample update on a single channel, then held
        wr_cfg(9, 0);
        wr_cfg(8, 2);
        e_mode = 0;
        e_freq = 2;
        run_frame(0, 0, 8'h00);
        run_frame(1, 1, 8'hA5);
        run_frame(1, 0, 8'h00);

        // R7: frequency write mid-frame defers to next frame
        run_frame(1, 2, 8'd6);
        run_frame(1, 0, 8'h00);

        // R8: addresses 10..15 change nothing
        for (int a = 10; a < 16; a++) wr_cfg(a, 8'h03);
        run_frame(0, 0, 8'h00);
        run_frame(1, 0, 8'h00);

        // R10: no progress while ticks are withheld
        begin
            int seen = 0;
            wait_stb("R10");
            ce_en = 1'b0;
            repeat (300) begin
                @(negedge clk);
                if (slot_stb) seen++;
            end
            chk("R10 strobes without tick", seen, 0);
            ce_en = 1'b1;
        end
        run_frame(0, 0, 8'h00);
        run_frame(1, 0, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule